// File: doc/BRIEF.md
# Grayscale Colormap Register Interface

This block is the CPU-facing side of a 16-level grayscale colour lookup table. Software first writes a colour number to an index register. It then streams component bytes through a data port. An internal byte pointer walks across the red, green and blue slots of successive palette entries, and it moves forward by one on every accepted data write.

Only bytes that land on a green slot change the palette. Such a byte is scaled by 0x11 into an 8-bit grey level and stored into all three components of sixteen entries spread across the 768-byte palette. These sixteen updates run one per clock. While they run, a busy flag is high and further data writes are dropped. If any of the sixteen entries held a different value before the update, a one-cycle redraw pulse tells the video side to repaint the whole screen.

A combinational read port lets the pixel pipeline look up any of the 256 entries. Two more byte registers, a clear colour and an overlay colour, are kept for software and only read back.

Top module: `gray_cmap`

## Requirements
- R1: Four 8-bit registers sit at byte offsets 0x0 (index), 0x4 (data), 0x8 (clear colour) and 0xC (overlay). A read (re_i) of one of them returns its last written value on rdata_o in the cycle after the read strobe. For the data register this is the last accepted data byte.
- R2: A write to any other offset changes nothing. A read of any other offset returns zero.
- R3: A write to the index register loads the byte pointer with (value[3:0])×3, so the next data byte lands in the red slot of that entry.
- R4: Every accepted data write moves the byte pointer forward by one, wrapping from 767 to 0. This happens whatever slot the write targets.
- R5: A data write whose pointer is on a red or blue slot (pointer mod 3 ≠ 1) leaves the palette unchanged and does not raise busy_o.
- R6: On a green-slot write the stored level is (data×0x11) mod 256. It is written to red (bits 23:16), green (15:8) and blue (7:0) of each affected entry.
- R7: A green write at pointer p updates entry ((p+16·i) mod 768)/3 for i = 0..15 and touches no other entry.
- R8: busy_o is high for exactly 16 cycles, starting the cycle after a green write. Data writes made while busy_o is high are ignored: they are not latched and do not move the pointer.
- R9: redraw_o pulses high for one cycle, in the cycle busy_o falls, if and only if at least one of the 16 entries changed value.
- R10: Reset clears all registers, the pointer, busy_o, redraw_o and every palette entry to zero.
- R11: pal_rgb_o shows the current content of entry pal_idx_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register byte offset |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after re_i |
| busy_o | output | 1 | Copy sequence running; data writes dropped |
| redraw_o | output | 1 | One-cycle full-screen redraw request |
| pal_idx_i | input | 8 | Palette lookup index |
| pal_rgb_o | output | 24 | Palette lookup result {R,G,B} |

## Verification
The bench sweeps every colour index and, after each burst of three component bytes, compares all 256 palette entries against an arithmetic model. A wrong copy stride or a missing mod-768 wrap would show up as misplaced grey entries. A long stream of data bytes walks the pointer past 767, so a pointer that fails to wrap, or that loses its slot phase, writes at the wrong slots. A repeated identical write must not raise redraw, and a data byte that arrives while busy must leave both the data register and the pointer untouched. A design that counted the dropped byte would shift every later green write by one slot. A level above 15 exercises the truncated ×0x11 scaling.

// File: rtl/gray_cmap_pkg.sv
package gray_cmap_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int RGB_W  = 3 * DATA_W;

  localparam logic [ADDR_W-1:0] OFF_INDEX = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_CLEAR = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_OVLY  = 4'hC;

  typedef enum logic [1:0] {SLOT_R = 2'd0, SLOT_G = 2'd1, SLOT_B = 2'd2} slot_e;
  typedef logic [RGB_W-1:0] rgb_t;
endpackage

// File: rtl/gray_cmap_csr.sv
module gray_cmap_csr
  import gray_cmap_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int ENTRIES = 256,
  localparam int BYTES  = 3 * ENTRIES,
  localparam int PTR_W  = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  output logic              start_o,
  output logic [PTR_W-1:0]  base_o,
  output logic [DATA_W-1:0] level_o
);
  logic [DATA_W-1:0] idx_q, data_q, clr_q, ovl_q, rdata_q;
  logic [PTR_W-1:0]  ptr_q;
  slot_e             slot_q;
  logic              idx_wr, data_acc;

  assign idx_wr   = we_i && (addr_i == OFF_INDEX);
  assign data_acc = we_i && (addr_i == OFF_DATA) && !busy_i;
  assign start_o  = data_acc && (slot_q == SLOT_G);
  assign base_o   = ptr_q;
  // x*0x11 mod 256 == x + (x[3:0] << 4)
  assign level_o  = wdata_i + {wdata_i[3:0], 4'h0};
  assign rdata_o  = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      data_q  <= '0;
      clr_q   <= '0;
      ovl_q   <= '0;
      rdata_q <= '0;
      ptr_q   <= '0;
      slot_q  <= SLOT_R;
    end else begin
      if (idx_wr) begin
        idx_q  <= wdata_i;
        ptr_q  <= PTR_W'(wdata_i[IDX_W-1:0]) * PTR_W'(3);
        slot_q <= SLOT_R;
      end
      if (data_acc) begin
        data_q <= wdata_i;
        ptr_q  <= (ptr_q == PTR_W'(BYTES - 1)) ? '0 : ptr_q + 1'b1;
        unique case (slot_q)
          SLOT_R:  slot_q <= SLOT_G;
          SLOT_G:  slot_q <= SLOT_B;
          default: slot_q <= SLOT_R;
        endcase
      end
      if (we_i && addr_i == OFF_CLEAR) clr_q <= wdata_i;
      if (we_i && addr_i == OFF_OVLY)  ovl_q <= wdata_i;
      if (re_i) begin
        unique case (addr_i)
          OFF_INDEX: rdata_q <= idx_q;
          OFF_DATA:  rdata_q <= data_q;
          OFF_CLEAR: rdata_q <= clr_q;
          OFF_OVLY:  rdata_q <= ovl_q;
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  AST_SLOT_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PTR_W'(slot_q) == ptr_q % PTR_W'(3)); // R4
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < PTR_W'(BYTES)); // R4
  AST_BUSY_HOLDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !idx_wr) |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/gray_cmap_seq.sv
module gray_cmap_seq
  import gray_cmap_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int ENTRIES = 256,
  localparam int COPIES = 1 << IDX_W,
  localparam int BYTES  = 3 * ENTRIES,
  localparam int PTR_W  = $clog2(BYTES),
  localparam int ENT_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  base_i,
  input  logic [DATA_W-1:0] level_i,
  input  rgb_t              old_rgb_i,
  output logic              busy_o,
  output logic              redraw_o,
  output logic              wr_en_o,
  output logic [ENT_W-1:0]  wr_idx_o,
  output rgb_t              wr_rgb_o
);
  logic              busy_q, chg_q, redraw_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  base_q;
  logic [DATA_W-1:0] lvl_q;
  logic [PTR_W:0]    sum;
  logic [PTR_W-1:0]  byte_pos;
  logic              differs;

  // copy stride equals COPIES, so offset is cnt shifted by IDX_W
  assign sum      = {1'b0, base_q} + (PTR_W+1)'({cnt_q, {IDX_W{1'b0}}});
  assign byte_pos = (sum >= (PTR_W+1)'(BYTES)) ? PTR_W'(sum - (PTR_W+1)'(BYTES)) : PTR_W'(sum);
  assign wr_idx_o = ENT_W'(byte_pos / PTR_W'(3));
  assign wr_rgb_o = {lvl_q, lvl_q, lvl_q};
  assign wr_en_o  = busy_q;
  assign differs  = (old_rgb_i != wr_rgb_o);
  assign busy_o   = busy_q;
  assign redraw_o = redraw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      chg_q    <= 1'b0;
      redraw_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      lvl_q    <= '0;
    end else begin
      redraw_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        chg_q  <= 1'b0;
        cnt_q  <= '0;
        base_q <= base_i;
        lvl_q  <= level_i;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (differs) chg_q <= 1'b1;
        if (cnt_q == IDX_W'(COPIES - 1)) begin
          busy_q   <= 1'b0;
          redraw_q <= chg_q | differs;
        end
      end
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R8
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == IDX_W'(COPIES - 1)) |=> !busy_q); // R8
  AST_REDRAW_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redraw_q |=> !redraw_q); // R9
  AST_REDRAW_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redraw_q |-> $fell(busy_q)); // R9
endmodule

// File: rtl/gray_cmap_store.sv
module gray_cmap_store
  import gray_cmap_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int ENT_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ENT_W-1:0] widx_i,
  input  rgb_t             wrgb_i,
  output rgb_t             wold_o,
  input  logic [ENT_W-1:0] ridx_i,
  output rgb_t             rrgb_o
);
  rgb_t pal_q [ENTRIES];

  assign wold_o = pal_q[widx_i];
  assign rrgb_o = pal_q[ridx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) pal_q[e] <= '0;
    end else if (we_i) begin
      pal_q[widx_i] <= wrgb_i;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (pal_q[$past(widx_i)] == $past(wrgb_i))); // R6
endmodule

// File: rtl/gray_cmap.sv
module gray_cmap
  import gray_cmap_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int ENTRIES = 256,
  localparam int BYTES  = 3 * ENTRIES,
  localparam int PTR_W  = $clog2(BYTES),
  localparam int ENT_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              redraw_o,
  input  logic [ENT_W-1:0]  pal_idx_i,
  output logic [RGB_W-1:0]  pal_rgb_o
);
  logic              start, wr_en;
  logic [PTR_W-1:0]  base;
  logic [DATA_W-1:0] level;
  logic [ENT_W-1:0]  wr_idx;
  rgb_t              wr_rgb, old_rgb;

  gray_cmap_csr #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_csr (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .re_i, .rdata_o,
    .busy_i(busy_o), .start_o(start), .base_o(base), .level_o(level)
  );

  gray_cmap_seq #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .base_i(base), .level_i(level),
    .old_rgb_i(old_rgb), .busy_o, .redraw_o, .wr_en_o(wr_en),
    .wr_idx_o(wr_idx), .wr_rgb_o(wr_rgb)
  );

  gray_cmap_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i, .rst_ni, .we_i(wr_en), .widx_i(wr_idx), .wrgb_i(wr_rgb),
    .wold_o(old_rgb), .ridx_i(pal_idx_i), .rrgb_o(pal_rgb_o)
  );

  AST_IDLE_NO_REDRAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !redraw_o); // R9
endmodule

// File: tb/gray_cmap_bench.sv
module gray_cmap_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy, redraw;
  logic [7:0]  pal_idx = '0;
  logic [23:0] pal_rgb;

  int checks = 0, fails = 0;
  logic [23:0] pal_m [256];
  int ptr_m = 0;
  logic [7:0] data_m = '0;

  always #10 clk = ~clk;

  gray_cmap u_gray_cmap (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .busy_o(busy), .redraw_o(redraw),
    .pal_idx_i(pal_idx), .pal_rgb_o(pal_rgb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic set_index(input logic [7:0] v);
    wr(4'h0, v);
    ptr_m = int'(v[3:0]) * 3;
  endtask

  // model + drive one accepted data write, checking busy/redraw timing
  task automatic put_data(input logic [7:0] v, input string req);
    logic [7:0] lvl;
    bit green, changed;
    int n, pulses;
    green = (ptr_m % 3 == 1);
    changed = 0;
    if (green) begin
      lvl = v + {v[3:0], 4'h0};
      for (int i = 0; i < 16; i++) begin
        int e;
        e = ((ptr_m + 16 * i) % 768) / 3;
        if (pal_m[e] != {lvl, lvl, lvl}) changed = 1;
        pal_m[e] = {lvl, lvl, lvl};
      end
    end
    wr(4'h4, v);
    data_m = v;
    ptr_m = (ptr_m + 1) % 768;
    if (!green) begin
      check({req, " R5 no busy on red/blue slot"}, busy, 0);
    end else begin
      n = 0; pulses = 0;
      while (busy && n < 40) begin
        if (redraw) pulses++;
        n++;
        @(negedge clk);
      end
      check({req, " R8 busy length"}, n, 16);
      check({req, " R9 no redraw while busy"}, pulses, 0);
      check({req, " R9 redraw at busy fall"}, redraw, changed);
      @(negedge clk);
      check({req, " R9 redraw single cycle"}, redraw, 0);
    end
  endtask

  task automatic cmp_palette(input string req);
    int bad;
    bad = 0;
    for (int e = 0; e < 256; e++) begin
      pal_idx = e[7:0];
      #1;
      if (pal_rgb !== pal_m[e]) begin
        if (bad == 0) check({req, " R7 palette entry"}, pal_rgb, pal_m[e]);
        bad++;
      end
    end
    if (bad == 0) check({req, " R7 palette matches"}, 0, 0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    for (int e = 0; e < 256; e++) pal_m[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 busy", busy, 0);
    check("R10 redraw", redraw, 0);
    rd(4'h0, r); check("R10 index", r, 0);
    rd(4'h4, r); check("R10 data", r, 0);
    rd(4'h8, r); check("R10 clear", r, 0);
    rd(4'hC, r); check("R10 overlay", r, 0);
    cmp_palette("R10 R11");

    // R1 readback
    wr(4'h8, 8'h5A); rd(4'h8, r); check("R1 clear", r, 8'h5A);
    wr(4'hC, 8'hC3); rd(4'hC, r); check("R1 overlay", r, 8'hC3);
    set_index(8'hA7); rd(4'h0, r); check("R1 index", r, 8'hA7);

    // R2 unmapped
    wr(4'h2, 8'hFF); wr(4'h9, 8'hEE);
    rd(4'h2, r); check("R2 unmapped read", r, 0);
    rd(4'hD, r); check("R2 unmapped read", r, 0);
    rd(4'h8, r); check("R2 clear kept", r, 8'h5A);
    rd(4'hC, r); check("R2 overlay kept", r, 8'hC3);
    // index 0xA7 -> ptr 21, red slot: first byte must not start (R3)
    put_data(8'h01, "R3");
    put_data(8'h09, "R3 green");
    put_data(8'h02, "R3");
    cmp_palette("R3 R6");

    // sweep all colour indices (R6 R7)
    for (int k = 0; k < 16; k++) begin
      set_index(8'(k));
      put_data(8'(k + 3), "R5 red");
      put_data(8'((k * 7 + 1) & 15), "R6 green");
      put_data(8'(k + 5), "R5 blue");
      rd(4'h4, r); check("R1 data readback", r, 8'(k + 5));
      cmp_palette("R6 sweep");
    end

    // same value twice: no redraw (R9)
    set_index(8'h04);
    put_data(8'h00, "R9 red");
    put_data(8'h0C, "R9 first");
    set_index(8'h04);
    put_data(8'h00, "R9 red");
    put_data(8'h0C, "R9 repeat");

    // R8: write during busy ignored
    set_index(8'h05);
    put_data(8'h01, "R8 red");
    begin
      logic [7:0] lvl;
      lvl = 8'h03 + 8'h30;
      for (int i = 0; i < 16; i++) pal_m[((ptr_m + 16 * i) % 768) / 3] = {lvl, lvl, lvl};
      wr(4'h4, 8'h03);
      ptr_m = ptr_m + 1; data_m = 8'h03;
      wr(4'h4, 8'h0B);  // dropped
      while (busy) @(negedge clk);
      @(negedge clk);
    end
    rd(4'h4, r); check("R8 dropped byte not latched", r, 8'h03);
    put_data(8'h07, "R8 blue after drop");
    put_data(8'h08, "R8 red after drop");
    put_data(8'h0E, "R8 green after drop");
    cmp_palette("R8");

    // long stream across pointer wrap, incl. levels above 15 (R4 R6)
    set_index(8'h0F);
    for (int k = 0; k < 772; k++) put_data(8'((k * 37 + 11) & 8'hFF), "R4 stream");
    cmp_palette("R4 wrap");
    put_data(8'h1F, "R6 wide");
    put_data(8'h06, "R4 next");
    cmp_palette("R6 wide level");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule